// File: doc/BRIEF.md
# Divided-Clock Phase Frequency Detector

This block measures how far a locally generated line clock drifts from an external reference. Both are first divided down to a common compare rate: the reference by a programmable ratio in its own clock domain, and the line clock by a second programmable ratio. The divided reference crosses into the line-clock domain through a synchroniser. Rising edges of both divided signals are then counted against each other in a signed accumulator.

A programmable integration window closes every `rateSet+1` line cycles. When it closes, the accumulated difference is presented as a signed error word with a one-cycle valid strobe, and the accumulator restarts. The error word feeds a downstream loop filter. When the loop is locked, the word sits near zero. A saturation flag reports windows whose sum hit the limits of the word. An optional dither term, taken from a 16-bit LFSR, breaks up the quantisation of the count. The reference may be any clock, or a train of single pulses, that is asynchronous to the line clock.

Top module: `pfd_phase_detect`

## Requirements
- R1: The local divider produces one rising edge every `lineDivSet+2` line-clock cycles. Each such edge subtracts one from the running window sum.
- R2: The reference divider counts rising edges of `refIn` and produces one divided rising edge every `refDivSet+2` of them. Each such edge adds one to the running sum. The divider is held clear in its own domain until the second `refIn` rising edge after reset release. This assumes at least two `refIn` rising edges occurred while reset was high.
- R3: A `refIn` rising edge that lands between line-clock edges k and k+1 and completes a reference division is added at line-clock edge k+3. This covers two synchroniser stages and one edge-detect stage.
- R4: `errValid` pulses high for exactly one cycle every `rateSet+1` line cycles. The first pulse follows the (`rateSet+1`)-th rising edge after reset release.
- R5: On each `errValid` pulse, `errWord` carries the two's-complement sum (reference edges minus local edges) of the window just closed, plus that window's start value. Between pulses, `errWord` and `errOvf` hold.
- R6: The first `errValid` pulse after reset carries `errWord` = 0 and `errOvf` = 0, whatever the edges counted.
- R7: The running sum saturates at +2^(ERR_W-1)-1 and -2^(ERR_W-1) instead of wrapping. `errOvf` is high with the word if the sum saturated at any point in that window. ERR_W defaults to 21.
- R8: With `ditherEn` high when a window closes, the next window starts at +1 if bit 0 of the LFSR is 1, and at -1 otherwise. With `ditherEn` low, it starts at 0. The LFSR is 16 bits and is loaded with 0xACE1 in reset. It shifts left every cycle, taking into bit 0 the XOR of bits 15, 13, 12 and 10.
- R9: While `rst` is high, `errWord`, `errValid` and `errOvf` read 0. The local divider, the synchroniser and the window counter restart from zero on release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lineClk | input | 1 | Line clock; all outputs are synchronous to it |
| rst | input | 1 | Synchronous active-high reset, held at least eight cycles |
| refIn | input | 1 | Asynchronous reference clock or pulse train, rising-edge sensitive |
| refDivSet | input | DIV_W | Reference division setting, divides by value+2 |
| lineDivSet | input | DIV_W | Line-clock division setting, divides by value+2 |
| rateSet | input | RATE_W | Integration window length minus one, in line cycles |
| ditherEn | input | 1 | Enables the LFSR start-value dither |
| errWord | output | ERR_W | Signed window error |
| errValid | output | 1 | One-cycle strobe with each new error word |
| errOvf | output | 1 | Window sum saturated |

## Verification
The detector is driven with five input patterns:
- Matched divided rates, which must give words within one count of zero.
- A reference that runs faster than the line clock, which gives a positive drift.
- A reference that runs slower, which gives a negative drift.
- A fast reference against an almost stalled local divider, which drives the sum into the positive limit.
- A silent reference, which drives the sum into the negative limit.

Together these separate sign errors, edge-counting errors, wrap-around instead of saturation, and a misplaced window boundary. A behavioural model tracks the exact cycle in which each synchronised edge lands, so a synchroniser stage added or removed shows up as a miscompare. Rerunning the matched pattern with dither enabled checks the ±1 start value against an independently stepped LFSR.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  localparam logic [15:0] LFSR_SEED = 16'hACE1;

  // Strobes from the window control to the datapath.
  typedef struct packed {
    logic winEnd;    // current cycle closes the window
    logic firstWin;  // window being closed is the first after reset
    logic ditherOn;  // next window starts with a dither value
    logic ditherUp;  // dither sign: 1 -> +1, 0 -> -1
  } pfdCtl_t;

endpackage

// File: rtl/pfd_divcnt.sv
// Programmable divider: divides clk by divSet+2, registered level output
module pfd_divcnt #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [DIV_W-1:0] divSet,
  output logic             lvl
);

  localparam int CW = DIV_W + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] lastVal;
  logic [CW-1:0] halfVal;
  logic [CW-1:0] nextCnt;

  assign lastVal = {1'b0, divSet} + CW'(1);
  assign halfVal = ({1'b0, divSet} + CW'(2)) >> 1;

  always_comb begin
    if (clr)                 nextCnt = '0;
    else if (cnt == lastVal) nextCnt = '0;
    else                     nextCnt = cnt + CW'(1);
  end

  always_ff @(posedge clk) begin
    cnt <= nextCnt;
    lvl <= (nextCnt >= halfVal);
  end

endmodule

// File: rtl/pfd_ctrl.sv
// Integration window timing, first-window flag and dither source
module pfd_ctrl
  import pfd_pkg::*;
#(
  parameter int RATE_W = 16
) (
  input  logic              lineClk,
  input  logic              rst,
  input  logic [RATE_W-1:0] rateSet,
  input  logic              ditherEn,
  output pfdCtl_t           ctl
);

  logic [RATE_W-1:0] rateCnt;
  logic              firstWin;
  logic [15:0]       lfsr;
  logic              lfsrFb;
  logic              winEnd;

  assign winEnd = (rateCnt >= rateSet);
  assign lfsrFb = lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10];

  always_ff @(posedge lineClk) begin
    if (rst) begin
      rateCnt  <= '0;
      firstWin <= 1'b1;
      lfsr     <= LFSR_SEED;
    end else begin
      rateCnt <= winEnd ? '0 : rateCnt + RATE_W'(1);
      if (winEnd) firstWin <= 1'b0;
      lfsr <= {lfsr[14:0], lfsrFb};
    end
  end

  always_comb begin
    ctl.winEnd   = winEnd;
    ctl.firstWin = firstWin;
    ctl.ditherOn = ditherEn;
    ctl.ditherUp = lfsr[0];
  end

endmodule

// File: rtl/pfd_datapath.sv
// Dividers, reference crossing, edge detection and saturating accumulator
module pfd_datapath
  import pfd_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int ERR_W       = 21,
  parameter int SYNC_STAGES = 2
) (
  input  logic             lineClk,
  input  logic             rst,
  input  logic             refIn,
  input  logic [DIV_W-1:0] refDivSet,
  input  logic [DIV_W-1:0] lineDivSet,
  input  pfdCtl_t          ctl,
  output logic [ERR_W-1:0] errWord,
  output logic             errValid,
  output logic             errOvf
);

  localparam logic [ERR_W-1:0] ACC_MAX = {1'b0, {(ERR_W-1){1'b1}}};
  localparam logic [ERR_W-1:0] ACC_MIN = {1'b1, {(ERR_W-1){1'b0}}};
  localparam logic [ERR_W-1:0] ONE_P   = ERR_W'(1);

  // ---- reference domain ----
  logic [1:0] refRstPipe;
  logic       refLvl;

  always_ff @(posedge refIn) refRstPipe <= {refRstPipe[0], rst};

  pfd_divcnt #(.DIV_W(DIV_W)) uRefDiv (
    .clk   (refIn),
    .clr   (refRstPipe[1]),
    .divSet(refDivSet),
    .lvl   (refLvl)
  );

  // ---- line domain ----
  logic lineLvl;
  logic lineLvlD;
  logic [SYNC_STAGES:0] syncChain;
  logic refEdge;
  logic lineEdge;

  pfd_divcnt #(.DIV_W(DIV_W)) uLineDiv (
    .clk   (lineClk),
    .clr   (rst),
    .divSet(lineDivSet),
    .lvl   (lineLvl)
  );

  generate
    if (SYNC_STAGES < 2) begin : gShortSync
      // too few stages for an asynchronous input: force the minimum of two
      logic [2:0] chainMin;
      always_ff @(posedge lineClk) begin
        if (rst) chainMin <= '0;
        else     chainMin <= {chainMin[1:0], refLvl};
      end
      assign refEdge   = chainMin[1] & ~chainMin[2];
      assign syncChain = '0;
    end else begin : gSync
      always_ff @(posedge lineClk) begin
        if (rst) syncChain <= '0;
        else     syncChain <= {syncChain[SYNC_STAGES-1:0], refLvl};
      end
      assign refEdge = syncChain[SYNC_STAGES-1] & ~syncChain[SYNC_STAGES];
    end
  endgenerate

  always_ff @(posedge lineClk) begin
    if (rst) lineLvlD <= 1'b0;
    else     lineLvlD <= lineLvl;
  end

  assign lineEdge = lineLvl & ~lineLvlD;

  // ---- accumulator ----
  logic [ERR_W-1:0] acc;
  logic             ovfWin;
  logic [ERR_W:0]   stepExt;
  logic [ERR_W:0]   sumExt;
  logic             satHit;
  logic             satHi;
  logic [ERR_W-1:0] satVal;
  logic [ERR_W-1:0] startVal;

  always_comb begin
    case ({refEdge, lineEdge})
      2'b10:   stepExt = (ERR_W+1)'(1);
      2'b01:   stepExt = '1;
      default: stepExt = '0;
    endcase
  end

  assign sumExt = {acc[ERR_W-1], acc} + stepExt;
  assign satHit = sumExt[ERR_W] ^ sumExt[ERR_W-1];
  assign satHi  = ~sumExt[ERR_W];

  always_comb begin
    if (satHit) satVal = satHi ? ACC_MAX : ACC_MIN;
    else        satVal = sumExt[ERR_W-1:0];
  end

  always_comb begin
    if (!ctl.ditherOn)    startVal = '0;
    else if (ctl.ditherUp) startVal = ONE_P;
    else                  startVal = '1;
  end

  always_ff @(posedge lineClk) begin
    if (rst) begin
      acc      <= '0;
      ovfWin   <= 1'b0;
      errWord  <= '0;
      errValid <= 1'b0;
      errOvf   <= 1'b0;
    end else begin
      errValid <= ctl.winEnd;
      if (ctl.winEnd) begin
        acc     <= startVal;
        ovfWin  <= 1'b0;
        errWord <= ctl.firstWin ? '0 : satVal;
        errOvf  <= ctl.firstWin ? 1'b0 : (ovfWin | satHit);
      end else begin
        acc    <= satVal;
        ovfWin <= ovfWin | satHit;
      end
    end
  end

endmodule

// File: rtl/pfd_phase_detect.sv
// Top: divided-clock phase frequency detector
module pfd_phase_detect
  import pfd_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int RATE_W      = 16,
  parameter int ERR_W       = 21,
  parameter int SYNC_STAGES = 2
) (
  input  logic              lineClk,
  input  logic              rst,
  input  logic              refIn,
  input  logic [DIV_W-1:0]  refDivSet,
  input  logic [DIV_W-1:0]  lineDivSet,
  input  logic [RATE_W-1:0] rateSet,
  input  logic              ditherEn,
  output logic [ERR_W-1:0]  errWord,
  output logic              errValid,
  output logic              errOvf
);

  pfdCtl_t ctl;

  pfd_ctrl #(.RATE_W(RATE_W)) uCtrl (
    .lineClk (lineClk),
    .rst     (rst),
    .rateSet (rateSet),
    .ditherEn(ditherEn),
    .ctl     (ctl)
  );

  pfd_datapath #(
    .DIV_W      (DIV_W),
    .ERR_W      (ERR_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) uData (
    .lineClk   (lineClk),
    .rst       (rst),
    .refIn     (refIn),
    .refDivSet (refDivSet),
    .lineDivSet(lineDivSet),
    .ctl       (ctl),
    .errWord   (errWord),
    .errValid  (errValid),
    .errOvf    (errOvf)
  );

endmodule

// File: rtl/pfd_phase_detect_chk.sv
module pfd_phase_detect_chk #(
  parameter int RATE_W = 16,
  parameter int ERR_W  = 21
) (
  input logic              lineClk,
  input logic              rst,
  input logic [RATE_W-1:0] rateSet,
  input logic [ERR_W-1:0]  errWord,
  input logic              errValid,
  input logic              errOvf
);

  logic seenValid;

  always_ff @(posedge lineClk) begin
    if (rst)           seenValid <= 1'b0;
    else if (errValid) seenValid <= 1'b1;
  end

  // R4: a window longer than one cycle never yields back-to-back strobes
  a_r4_valid_gap: assert property (@(posedge lineClk) disable iff (rst)
    (errValid && rateSet != '0) |=> !errValid);

  // R5: the error word only moves together with its strobe
  a_r5_word_hold: assert property (@(posedge lineClk) disable iff (rst)
    !errValid |-> $stable(errWord));

  // R7: the saturation flag only moves together with the strobe
  a_r7_ovf_hold: assert property (@(posedge lineClk) disable iff (rst)
    !errValid |-> $stable(errOvf));

  // R6: first strobe after reset carries a zero word and no overflow
  a_r6_first_zero: assert property (@(posedge lineClk) disable iff (rst)
    (errValid && !seenValid) |-> (errWord == '0 && !errOvf));

endmodule

bind pfd_phase_detect pfd_phase_detect_chk #(.RATE_W(RATE_W), .ERR_W(ERR_W)) uChk (
  .lineClk (lineClk),
  .rst     (rst),
  .rateSet (rateSet),
  .errWord (errWord),
  .errValid(errValid),
  .errOvf  (errOvf)
);

// File: tb/sim_pfd_phase_detect.sv
`timescale 1ns/1ps
module sim_pfd_phase_detect;

  localparam int EW = 8;
  localparam int HI = (1 << (EW-1)) - 1;
  localparam int LO = -(1 << (EW-1));

  logic          lineClk = 1'b0;
  logic          rst = 1'b1;
  logic          refIn = 1'b0;
  logic [15:0]   refDivSet = '0;
  logic [15:0]   lineDivSet = '0;
  logic [15:0]   rateSet = 16'd15;
  logic          ditherEn = 1'b0;
  logic [EW-1:0] errWord;
  logic          errValid;
  logic          errOvf;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  string tag = "R9";
  int refPeriod = 2;
  int refPh = 0;
  bit done = 0;

  always #5 lineClk = ~lineClk;

  pfd_phase_detect #(.ERR_W(EW)) u0 (
    .lineClk(lineClk), .rst(rst), .refIn(refIn),
    .refDivSet(refDivSet), .lineDivSet(lineDivSet), .rateSet(rateSet),
    .ditherEn(ditherEn), .errWord(errWord), .errValid(errValid), .errOvf(errOvf)
  );

  // ---------------- behavioural model ----------------
  int mRefCnt = 0;
  int mRefSkip = 2;
  bit mRefLvl = 0;
  int hist[$] = '{0, 0, 0};
  int mLineCnt = 0;
  bit mLineLvl = 0, mLineLvlD = 0;
  int mRate = 0;
  int mAcc = 0;
  bit mOvfW = 0, mFirst = 1;
  logic [15:0] mLfsr = 16'hACE1;
  int expWord = 0;
  bit expValid = 0, expOvf = 0;

  // reference stimulus, away from both line-clock edges
  always @(negedge lineClk) begin
    #2;
    if (refPeriod >= 2) begin
      refPh = (refPh + 1 >= refPeriod) ? 0 : refPh + 1;
      if (refPh == 0) begin
        refIn = 1'b1;
        // R2: divider cleared in reset and for two edges after release
        if (rst) begin
          mRefSkip = 2;
          mRefCnt = 0;
        end else if (mRefSkip > 0) begin
          mRefSkip--;
          mRefCnt = 0;
        end else begin
          mRefCnt = (mRefCnt == refDivSet + 1) ? 0 : mRefCnt + 1;
        end
        mRefLvl = (mRefCnt >= (refDivSet + 2) / 2);
      end else begin
        refIn = 1'b0;
      end
    end else begin
      refIn = 1'b0;
    end
  end

  always @(posedge lineClk) begin
    int step, s;
    bit rE, lE, wEnd, sat;
    if (rst) begin
      hist = '{0, 0, 0};
      mLineCnt = 0; mLineLvl = 0; mLineLvlD = 0;
      mRate = 0; mAcc = 0; mOvfW = 0; mFirst = 1;
      mLfsr = 16'hACE1;
      expWord = 0; expValid = 0; expOvf = 0;
    end else begin
      rE = (hist[1] != 0) && (hist[2] == 0);      // R3: two stages then edge
      lE = mLineLvl && !mLineLvlD;                // R1
      step = int'(rE) - int'(lE);
      wEnd = (mRate >= rateSet);                  // R4
      s = mAcc + step;
      sat = (s > HI) || (s < LO);                 // R7
      if (s > HI) s = HI;
      if (s < LO) s = LO;
      expValid = wEnd;
      if (wEnd) begin
        expWord = mFirst ? 0 : s;                 // R6
        expOvf  = mFirst ? 0 : (mOvfW || sat);
        mFirst = 0; mOvfW = 0;
        mAcc = ditherEn ? (mLfsr[0] ? 1 : -1) : 0; // R8
      end else begin
        mAcc = s;
        mOvfW = mOvfW || sat;
      end
      mRate = wEnd ? 0 : mRate + 1;
      mLfsr = {mLfsr[14:0], mLfsr[15] ^ mLfsr[13] ^ mLfsr[12] ^ mLfsr[10]};
      hist.push_front(int'(mRefLvl));
      void'(hist.pop_back());
      mLineLvlD = mLineLvl;
      mLineCnt = (mLineCnt == lineDivSet + 1) ? 0 : mLineCnt + 1;
      mLineLvl = (mLineCnt >= (lineDivSet + 2) / 2);
    end
  end

  // per-cycle comparison
  always @(negedge lineClk) begin
    cycles++;
    vectors++;
    if ($signed(errWord) != expWord || errValid != expValid || errOvf != expOvf) begin
      fails++;
      $display("FAIL %s cycle %0d: word/valid/ovf act %0d/%0b/%0b exp %0d/%0b/%0b",
               tag, cycles, $signed(errWord), errValid, errOvf, expWord, expValid, expOvf);
    end
    if (cycles > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog: act running exp finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic check(input string req, input bit ok, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act %0d exp %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge lineClk);
    rst = 1'b1;
    repeat (10) @(negedge lineClk);
    // R9: outputs idle during reset
    check("R9 word", errWord == '0, $signed(errWord), 0);
    check("R9 valid", errValid == 1'b0, errValid, 0);
    check("R9 ovf", errOvf == 1'b0, errOvf, 0);
    rst = 1'b0;
  endtask

  // wait for n strobes, returning the last word
  task automatic waitWords(input int n, output int lastWord, output bit lastOvf);
    lastWord = 0; lastOvf = 0;
    for (int i = 0; i < n; i++) begin
      do @(negedge lineClk); while (!errValid);
      lastWord = $signed(errWord);
      lastOvf = errOvf;
    end
  endtask

  initial begin
    int w, cnt;
    bit o;
    // ---- R4 / R6 / R9: window timing from reset release ----
    tag = "R4 R9";
    refPeriod = 2; refDivSet = 0; lineDivSet = 2; rateSet = 15; ditherEn = 0;
    doReset();
    cnt = 0;
    for (int i = 1; i <= 160; i++) begin
      @(negedge lineClk);
      if (errValid) begin
        cnt++;
        if (cnt == 1) begin
          check("R4 first strobe cycle", i == 16, i, 16);
          check("R6 first word zero", errWord == '0 && !errOvf, $signed(errWord), 0);
        end
      end
    end
    check("R4 strobe count", cnt == 10, cnt, 10);

    // ---- matched rates: near zero ----
    tag = "R1 R2 R3 R5";
    rateSet = 63;
    doReset();
    waitWords(6, w, o);
    check("R5 matched within one", w >= -1 && w <= 1, w, 0);

    // ---- reference faster ----
    tag = "R2 R3 R5";
    refPeriod = 2; refDivSet = 0; lineDivSet = 6;
    doReset();
    waitWords(5, w, o);
    check("R5 positive drift", w > 0 && !o, w, 8);

    // ---- reference slower ----
    tag = "R1 R3 R5";
    refPeriod = 3; refDivSet = 1; lineDivSet = 0;
    doReset();
    waitWords(5, w, o);
    check("R5 negative drift", w < 0 && !o, w, -25);

    // ---- positive saturation ----
    tag = "R7";
    refPeriod = 2; refDivSet = 0; lineDivSet = 16'hFFFF; rateSet = 1023;
    doReset();
    waitWords(3, w, o);
    check("R7 positive limit", w == HI && o, w, HI);

    // ---- negative saturation, silent reference ----
    refPeriod = 0; lineDivSet = 0;
    doReset();
    waitWords(3, w, o);
    check("R7 negative limit", w == LO && o, w, LO);

    // ---- dither ----
    tag = "R8";
    refPeriod = 2; refDivSet = 0; lineDivSet = 2; rateSet = 31; ditherEn = 1;
    doReset();
    waitWords(12, w, o);
    check("R8 dithered matched", w >= -2 && w <= 2, w, 0);
    ditherEn = 0;

    repeat (5) @(negedge lineClk);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule